// File: doc/BRIEF.md
# SPI Status Register Command Unit

This block is the status-register front end of a serial memory slave on an SPI mode 0 bus. While chip select is low it collects instruction bytes from the serial input. It acts on three commands: one sets the write-enable latch, one returns the status byte on the serial output, and one loads new status bits. All other instruction bytes are ignored until chip select rises again.

The status byte holds these fields:

- a read-only ready/busy flag that mirrors an external store or recall engine;
- the write-enable latch;
- a two-bit block-protect level;
- three spare bits that can be read and written;
- a protect-pin enable bit.

The block drives the block-protect level to the memory array. It also drives a write-inhibit flag, which is high when the protect-pin enable bit is set and the protect pin is held low.

The bus pins are sampled with a fast system clock through synchronizers. Bus edges are found by oversampling, so the serial clock never clocks any flop directly. The serial output comes with a separate enable, so that a tri-state pad can be built at the chip edge.

Top module: `spi_sr_ctrl`

## Requirements
- R1: After reset every stored status bit is 0, bp_o is 0, wr_inhibit_o is 0, so_oe_o is 0, and a status read returns 0x00 while busy_i is low.
- R2: A complete 8-bit instruction 0x06, sampled MSB first on rising SCK edges while cs_ni is low, sets the write-enable latch (status bit 1).
- R3: After the 8-bit instruction 0x05, the status byte is driven on so_o MSB first, starting at the 8th falling SCK edge and changing on each falling edge. It is reloaded every 8 bits while cs_ni stays low. The byte layout is: bit 7 protect-pin enable, bits 6..4 spare, bits 3..2 block-protect level, bit 1 write-enable latch, bit 0 ready/busy.
- R4: Bit 0 of each status byte sent equals busy_i at the moment that byte is loaded for output.
- R5: Instruction 0x01 followed by 8 data bits is committed when cs_ni rises, provided the write-enable latch is 1 and wr_inhibit_o is 0. At commit, status bits 7..2 take data bits 7..2, and data bits 1..0 are ignored.
- R6: A status write issued while the write-enable latch is 0 leaves status bits 7..2 unchanged.
- R7: The write-enable latch clears when any complete status write frame ends, whether or not the write was committed.
- R8: A frame whose cs_ni rises before all of its bits have arrived (8 for 0x06, 16 for 0x01) has no effect.
- R9: An instruction byte other than 0x06, 0x05 or 0x01, and every bit that follows it in the same frame, changes no state and leaves so_oe_o low.
- R10: so_oe_o is 0 while cs_ni is high and during the instruction byte. It is 1 only while status data is being sent.
- R11: wr_inhibit_o is 1 exactly when status bit 7 is 1 and wp_ni is low. While it is 1, status writes are blocked even when the write-enable latch is 1. When bit 7 is 0, wp_ni has no effect.
- R12: bp_o equals status bits 3..2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock, mode 0 |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for the so_o pad; when low, the pad is high-impedance |
| busy_i | input | 1 | High while a store or recall cycle is in progress |
| wp_ni | input | 1 | Protect pin, active low |
| bp_o | output | 2 | Block-protect level |
| wr_inhibit_o | output | 1 | Effective write-inhibit flag |

## Verification
The bound checker watches four rules on every cycle:

- the output enable falls once chip select is high;
- the write-enable latch rises only after a decoded enable instruction;
- the latch is cleared after every finished status write;
- the stored bits change only at a commit with the latch set, and never while writes are inhibited.

Other behaviours need the directed scenarios, because only they show the bus-level timing and the field values. These are the MSB-first byte layout, the per-byte sampling of the busy flag, the dropping of truncated frames and unknown instructions, and the masking of bits 1..0 in the written data.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
  // bits a status write may change
  localparam logic [BYTE_W-1:0] WR_MASK  = 8'hFC;
  localparam int WEN_BIT = 1;
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/spi_sr_frame.sv
module spi_sr_frame import spi_sr_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_hi_i,
  input  logic              cs_rise_i,
  input  logic              sck_rise_i,
  input  logic              si_i,
  output logic              wren_o,
  output logic              rd_o,
  output logic              wr_done_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int CW = $clog2(2*BYTE_W + 1);
  localparam logic [CW-1:0] OP_LAST  = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] DAT_LAST = CW'(2*BYTE_W - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(2*BYTE_W);

  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-2:0] sh_q;
  logic [BYTE_W-1:0] op_q, data_q;
  logic              full_q, rd_q;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {sh_q, si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      op_q   <= '0;
      data_q <= '0;
      full_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (cs_hi_i) begin
      cnt_q  <= '0;
      op_q   <= '0;
      full_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (sck_rise_i) begin
      sh_q <= byte_in[BYTE_W-2:0];
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == OP_LAST) begin
        op_q <= byte_in;
        rd_q <= (byte_in == OP_RDSR);
      end
      if (cnt_q == DAT_LAST && op_q == OP_WRSR) begin
        data_q <= byte_in;
        full_q <= 1'b1;
      end
    end
  end

  assign wren_o    = sck_rise_i && !cs_hi_i && cnt_q == OP_LAST && byte_in == OP_WREN;
  assign rd_o      = rd_q;
  assign wr_done_o = cs_rise_i && full_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/spi_sr_regs.sv
module spi_sr_regs import spi_sr_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wr_done_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              wp_ni,
  output logic [BYTE_W-1:0] status_o,
  output logic              wen_o,
  output logic              inhibit_o
);
  logic [BYTE_W-1:0] st_q;
  logic              wen_q;

  assign inhibit_o = st_q[BYTE_W-1] & ~wp_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      wen_q <= 1'b0;
    end else begin
      if (wren_i) wen_q <= 1'b1;
      if (wr_done_i) begin
        wen_q <= 1'b0;
        if (wen_q && !inhibit_o) st_q <= (st_q & ~WR_MASK) | (wr_data_i & WR_MASK);
      end
    end
  end

  always_comb begin
    status_o          = st_q & WR_MASK;
    status_o[WEN_BIT] = wen_q;
    status_o[0]       = busy_i;
  end

  assign wen_o = wen_q;
endmodule

// File: rtl/spi_sr_tx.sv
module spi_sr_tx import spi_sr_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_hi_i,
  input  logic              sck_fall_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              so_o,
  output logic              oe_o
);
  localparam int TW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [TW-1:0]     cnt_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (cs_hi_i) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (rd_i && sck_fall_i) begin
      // reload a fresh snapshot at each byte boundary
      if (cnt_q == '0) sh_q <= status_i;
      else             sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
      oe_q  <= 1'b1;
    end
  end

  assign so_o = sh_q[BYTE_W-1];
  assign oe_o = oe_q;
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl import spi_sr_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       si_i,
  output logic       so_o,
  output logic       so_oe_o,
  input  logic       busy_i,
  input  logic       wp_ni,
  output logic [1:0] bp_o,
  output logic       wr_inhibit_o
);
  logic cs_s, sck_s, si_s, busy_s, wp_s;
  logic cs_d, sck_d;
  logic cs_rise, sck_rise, sck_fall;
  logic wren_p, rd_act, wr_done, wen;
  logic [BYTE_W-1:0] wr_data, stat_byte;

  spi_sr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i, .rst_ni, .d_i(cs_ni), .q_o(cs_s));
  spi_sr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk_i, .rst_ni, .d_i(sck_i), .q_o(sck_s));
  spi_sr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
    .clk_i, .rst_ni, .d_i(si_i), .q_o(si_s));
  spi_sr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_busy (
    .clk_i, .rst_ni, .d_i(busy_i), .q_o(busy_s));
  spi_sr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wp (
    .clk_i, .rst_ni, .d_i(wp_ni), .q_o(wp_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_rise  = cs_s & ~cs_d;
  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;

  spi_sr_frame u_frame (
    .clk_i, .rst_ni,
    .cs_hi_i   (cs_s),
    .cs_rise_i (cs_rise),
    .sck_rise_i(sck_rise),
    .si_i      (si_s),
    .wren_o    (wren_p),
    .rd_o      (rd_act),
    .wr_done_o (wr_done),
    .wr_data_o (wr_data)
  );

  spi_sr_regs u_regs (
    .clk_i, .rst_ni,
    .wren_i   (wren_p),
    .wr_done_i(wr_done),
    .wr_data_i(wr_data),
    .busy_i   (busy_s),
    .wp_ni    (wp_s),
    .status_o (stat_byte),
    .wen_o    (wen),
    .inhibit_o(wr_inhibit_o)
  );

  spi_sr_tx u_tx (
    .clk_i, .rst_ni,
    .cs_hi_i   (cs_s),
    .sck_fall_i(sck_fall),
    .rd_i      (rd_act),
    .status_i  (stat_byte),
    .so_o      (so_o),
    .oe_o      (so_oe_o)
  );

  assign bp_o = stat_byte[3:2];
endmodule

// File: rtl/spi_sr_ctrl_chk.sv
module spi_sr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       so_oe_o,
  input logic       wen,
  input logic       wren_p,
  input logic       wr_done,
  input logic       wr_inhibit_o,
  input logic [5:0] held
);
  a_r10_oe_off_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !so_oe_o);

  a_r2_wen_set_by_wren: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wen) |-> $past(wren_p));

  a_r7_wen_cleared_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |=> !wen);

  a_r6_bits_change_only_on_enabled_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(held) |-> ($past(wen) && $past(wr_done)));

  a_r11_inhibit_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_inhibit_o && wr_done) |=> $stable(held));
endmodule

bind spi_sr_ctrl spi_sr_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_s        (cs_s),
  .so_oe_o     (so_oe_o),
  .wen         (wen),
  .wren_p      (wren_p),
  .wr_done     (wr_done),
  .wr_inhibit_o(wr_inhibit_o),
  .held        (stat_byte[7:2])
);

// File: tb/spi_sr_ctrl_test.sv
`timescale 1ns/1ps
module spi_sr_ctrl_test;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, si_i = 1'b0;
  logic busy_i = 1'b0, wp_ni = 1'b1;
  logic so_o, so_oe_o, wr_inhibit_o;
  logic [1:0] bp_o;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  spi_sr_ctrl uut (
    .clk_i(clk), .rst_ni, .cs_ni, .sck_i, .si_i, .so_o, .so_oe_o,
    .busy_i, .wp_ni, .bp_o, .wr_inhibit_o);

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=0x%02h exp=0x%02h", req, act, exp);
    end
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs_ni = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HP) @(negedge clk);
    cs_ni = 1'b1;
    repeat (3*HP) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n,
                          output logic [7:0] rx, output int oe_n);
    rx = '0;
    oe_n = 0;
    for (int i = 0; i < n; i++) begin
      si_i = tx[7-i];
      repeat (HP) @(negedge clk);
      rx = {rx[6:0], so_o};
      oe_n += int'(so_oe_o);
      sck_i = 1'b1;
      repeat (HP) @(negedge clk);
      sck_i = 1'b0;
    end
  endtask

  task automatic rd_status(input string req, input logic [7:0] exp);
    logic [7:0] rx;
    int oe_n;
    cs_on();
    spi_bits(8'h05, 8, rx, oe_n);
    chk("R10 oe low during opcode", 8'(oe_n), 8'd0);
    spi_bits(8'h00, 8, rx, oe_n);
    chk(req, rx, exp);
    chk("R10 oe high during data", 8'(oe_n), 8'd8);
    cs_off();
    chk("R10 oe low after deselect", {7'd0, so_oe_o}, 8'd0);
  endtask

  task automatic wren();
    logic [7:0] rx;
    int oe_n;
    cs_on();
    spi_bits(8'h06, 8, rx, oe_n);
    cs_off();
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [7:0] rx;
    int oe_n;
    cs_on();
    spi_bits(8'h01, 8, rx, oe_n);
    spi_bits(d, 8, rx, oe_n);
    cs_off();
  endtask

  task automatic t_reset();
    chk("R1 bp_o", {6'd0, bp_o}, 8'd0);
    chk("R1 wr_inhibit_o", {7'd0, wr_inhibit_o}, 8'd0);
    chk("R1 so_oe_o", {7'd0, so_oe_o}, 8'd0);
    rd_status("R1 R3 reset status", 8'h00);
  endtask

  task automatic t_wren();
    wren();
    rd_status("R2 wen set", 8'h02);
  endtask

  task automatic t_rdy();
    logic [7:0] a, b, rx;
    int oe_n;
    busy_i = 1'b1;
    cs_on();
    spi_bits(8'h05, 8, rx, oe_n);
    spi_bits(8'h00, 4, a, oe_n);
    busy_i = 1'b0;
    spi_bits(8'h00, 4, b, oe_n);
    chk("R4 busy byte", {a[3:0], b[3:0]}, 8'h03);
    spi_bits(8'h00, 8, rx, oe_n);
    chk("R3 R4 repeated byte idle", rx, 8'h02);
    cs_off();
  endtask

  task automatic t_write();
    wrsr(8'hFF);
    rd_status("R5 R7 write FF", 8'hFC);
    chk("R12 bp_o", {6'd0, bp_o}, 8'd3);
  endtask

  task automatic t_nowen();
    wrsr(8'h00);
    rd_status("R6 write without wen", 8'hFC);
  endtask

  task automatic t_short();
    logic [7:0] rx;
    int oe_n;
    cs_on();
    spi_bits(8'h06, 5, rx, oe_n);
    cs_off();
    rd_status("R8 short wren", 8'hFC);
    wren();
    cs_on();
    spi_bits(8'h01, 8, rx, oe_n);
    spi_bits(8'h00, 3, rx, oe_n);
    cs_off();
    rd_status("R8 short write", 8'hFE);
  endtask

  task automatic t_unknown();
    logic [7:0] rx;
    int oe_n, oe_m;
    cs_on();
    spi_bits(8'h9F, 8, rx, oe_n);
    spi_bits(8'hAA, 8, rx, oe_m);
    cs_off();
    chk("R9 no drive", 8'(oe_n + oe_m), 8'd0);
    rd_status("R9 state kept", 8'hFE);
  endtask

  task automatic t_protect();
    wrsr(8'h84);
    rd_status("R5 write 84", 8'h84);
    chk("R12 bp_o level 1", {6'd0, bp_o}, 8'd1);
    @(negedge clk);
    wp_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 inhibit on", {7'd0, wr_inhibit_o}, 8'd1);
    wren();
    wrsr(8'h00);
    rd_status("R11 R7 blocked write", 8'h84);
    wp_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 inhibit off", {7'd0, wr_inhibit_o}, 8'd0);
    wren();
    wrsr(8'h08);
    rd_status("R5 write 08", 8'h08);
    wp_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 pin ignored", {7'd0, wr_inhibit_o}, 8'd0);
    wren();
    wrsr(8'h70);
    rd_status("R5 spare bits", 8'h70);
    chk("R12 bp_o zero", {6'd0, bp_o}, 8'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_wren();
    t_rdy();
    t_write();
    t_nowen();
    t_short();
    t_unknown();
    t_protect();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule